// File: doc/BRIEF.md
# Control Endpoint Mode and Status Register

This block holds the response mode and the transaction status flags of a USB device's bidirectional control endpoint. Two agents share it. The serial interface engine (SIE) posts a one-cycle update when a transaction's token phase ends. The update names the token type and says whether the transaction closed with an acknowledge. The CPU reads the register, sets the four-bit response mode, and clears the status flags it has handled.

Each SIE update locks the low seven bits against CPU writes, so the CPU cannot overwrite status it has not yet seen. Reading the register releases the lock on the next clock edge. Any CPU write clears the setup-received flag, whatever data it carries. While that flag is set, the block withholds the CPU's write strobe to the control endpoint buffer, so setup data still waiting to be read cannot be overwritten. Through the data phase of a setup transaction, the SIE holds the flag high with a separate level input.

Bit layout, as read on `cpu_rdata`: [3:0] response mode, [4] acknowledged, [5] OUT token seen, [6] IN token seen, [7] SETUP token seen.

Top module: `ep0_mode_reg`

## Requirements
- R1: After reset every bit of `cpu_rdata` reads 0.
- R2: When `sie_upd` is high, the token code on `sie_tok` sets one flag on the next edge: 2'b01 sets bit 5 (OUT), 2'b10 sets bit 6 (IN), 2'b11 sets bit 7 (SETUP), and 2'b00 sets none. The other bits are left unchanged.
- R3: A SIE update with `sie_ack` high sets bit 4 on the next edge.
- R4: Bits 6:4 are sticky. Outside a SIE update they do not change, except that an unlocked CPU write with a 0 in a bit's position clears that bit. A 1 written by the CPU never sets one of these bits.
- R5: A CPU write that does not coincide with a SIE update clears bit 7, whatever the data and whether or not the register is locked.
- R6: An unlocked CPU write loads `cpu_wdata[3:0]` into the mode field, and the new value shows on `cpu_rdata` after the next edge. The mode field never changes otherwise.
- R7: After a SIE update the register is locked: CPU writes leave bits 6:0 unchanged until the lock is removed.
- R8: A CPU read in a cycle with no SIE update removes the lock at the following edge. The data returned during the read cycle is the current register value.
- R9: When a SIE update and a CPU write arrive in the same cycle, the SIE update is applied, the CPU write is discarded, and the register is locked.
- R10: While `sie_setup_hold` is high, bit 7 is set on the next edge, even if a CPU write clears it in the same cycle.
- R11: `buf_wr_en` equals `buf_wr` while bit 7 is 0, and it is 0 while bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register contents |
| sie_upd | input | 1 | One-cycle SIE update strobe |
| sie_tok | input | 2 | Token code: 01 OUT, 10 IN, 11 SETUP, 00 none |
| sie_ack | input | 1 | Transaction closed with an acknowledge |
| sie_setup_hold | input | 1 | Setup data phase in progress; forces bit 7 |
| buf_wr | input | 1 | CPU write strobe to the endpoint buffer |
| buf_wr_en | output | 1 | Qualified buffer write strobe |

## Verification
The assertions assume only that the strobe inputs are clean single-bit levels sampled at the rising edge. They place no restriction on how the strobes overlap: reads, writes, updates and the setup hold may coincide in any combination. The random stimulus therefore draws every input on every cycle with independent probabilities, and these are tuned so that locked and unlocked states, coinciding SIE and CPU accesses, and setup-hold intervals all occur often. Directed sequences add the exact orderings of lock, read release and same-cycle conflict.

// File: rtl/ep0_mode_reg.sv
module ep0_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       sie_upd,
  input  logic [1:0] sie_tok,
  input  logic       sie_ack,
  input  logic       sie_setup_hold,
  input  logic       buf_wr,
  output logic       buf_wr_en
);
  localparam logic [1:0] TOK_OUT   = 2'b01;
  localparam logic [1:0] TOK_IN    = 2'b10;
  localparam logic [1:0] TOK_SETUP = 2'b11;

  logic [7:0] st, st_nx;
  logic       lock, lock_nx;

  always_comb begin
    st_nx = st;
    if (sie_upd) begin
      if (sie_ack) st_nx[4] = 1'b1;
      case (sie_tok)
        TOK_OUT:   st_nx[5] = 1'b1;
        TOK_IN:    st_nx[6] = 1'b1;
        TOK_SETUP: st_nx[7] = 1'b1;
        default:   ;
      endcase
    end else if (cpu_wr) begin
      st_nx[7] = 1'b0;
      if (!lock) begin
        st_nx[3:0] = cpu_wdata[3:0];
        st_nx[6:4] = st[6:4] & cpu_wdata[6:4];
      end
    end
    if (sie_setup_hold) st_nx[7] = 1'b1;
  end

  assign lock_nx = sie_upd ? 1'b1 : (cpu_rd ? 1'b0 : lock);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      lock <= 1'b0;
    end else begin
      st   <= st_nx;
      lock <= lock_nx;
    end
  end

  assign cpu_rdata = st;
  assign buf_wr_en = buf_wr & ~st[7];

  AST_TOK_IN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sie_upd && sie_tok == TOK_IN |=> cpu_rdata[6]); // R2
  AST_TOK_OUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sie_upd && sie_tok == TOK_OUT |=> cpu_rdata[5]); // R2
  AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sie_upd && sie_ack |=> cpu_rdata[4]); // R3
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> (cpu_rdata[6:4] & $past(cpu_rdata[6:4])) == $past(cpu_rdata[6:4])); // R4
  AST_WR_CLEARS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !sie_upd && !sie_setup_hold |=> !cpu_rdata[7]); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr || sie_upd || lock |=> $stable(cpu_rdata[3:0])); // R6
  AST_LOCKED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    lock && cpu_wr && !sie_upd |=> $stable(cpu_rdata[6:0])); // R7
  AST_READ_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !sie_upd |=> !lock); // R8
  AST_SIE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sie_upd |=> lock); // R9
  AST_HOLD_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup_hold |=> cpu_rdata[7]); // R10
endmodule

// File: tb/ep0_mode_reg_bench.sv
`timescale 1ns/100ps
module ep0_mode_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 0, cpu_rd = 0, sie_upd = 0, sie_ack = 0, sie_setup_hold = 0, buf_wr = 0;
  logic [7:0] cpu_wdata = '0;
  logic [1:0] sie_tok = '0;
  logic [7:0] cpu_rdata;
  logic       buf_wr_en;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_st = '0;
  logic       m_lock = 1'b0;

  always #2.5 clk = ~clk;

  ep0_mode_reg u_ep0_mode_reg (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .sie_upd(sie_upd), .sie_tok(sie_tok), .sie_ack(sie_ack),
    .sie_setup_hold(sie_setup_hold), .buf_wr(buf_wr), .buf_wr_en(buf_wr_en));

  function automatic logic [8:0] model_next(input logic [7:0] s, input logic lk,
      input logic wr, input logic rd, input logic [7:0] wd, input logic upd,
      input logic [1:0] tok, input logic ack, input logic hold);
    logic [7:0] n = s;
    logic nl = lk;
    if (upd) begin
      n[4] = n[4] | ack;
      n[5] = n[5] | (tok == 2'b01);
      n[6] = n[6] | (tok == 2'b10);
      n[7] = n[7] | (tok == 2'b11);
      nl = 1'b1;
    end else begin
      if (wr) begin
        n[7] = 1'b0;
        if (!lk) n[6:0] = {s[6:4] & wd[6:4], wd[3:0]};
      end
      if (rd) nl = 1'b0;
    end
    if (hold) n[7] = 1'b1;
    return {nl, n};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic wr, input logic rd, input logic [7:0] wd,
      input logic upd, input logic [1:0] tok, input logic ack, input logic hold, input logic bw);
    logic [8:0] nx;
    cpu_wr = wr; cpu_rd = rd; cpu_wdata = wd; sie_upd = upd; sie_tok = tok;
    sie_ack = ack; sie_setup_hold = hold; buf_wr = bw;
    #1;
    check("R11 buf_wr_en", {7'd0, buf_wr_en}, {7'd0, bw & ~m_st[7]});
    if (rd) check("R8 read data", cpu_rdata, m_st);
    nx = model_next(m_st, m_lock, wr, rd, wd, upd, tok, ack, hold);
    @(negedge clk);
    m_st = nx[7:0];
    m_lock = nx[8];
    check(tag, cpu_rdata, m_st);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", cpu_rdata, 8'h00);
    step("R6 mode write", 1, 0, 8'h0A, 0, 0, 0, 0, 0);
    step("R2 IN token", 0, 0, 8'h00, 1, 2'b10, 1, 0, 0);
    step("R3 ack after IN", 0, 0, 8'h00, 0, 0, 0, 0, 0);
    step("R7 locked write", 1, 0, 8'h05, 0, 0, 0, 0, 0);
    step("R8 read releases", 0, 1, 8'h00, 0, 0, 0, 0, 0);
    step("R4 write 1 keeps, write 0 clears", 1, 0, 8'h23, 0, 0, 0, 0, 0);
    step("R2 SETUP token", 0, 0, 8'h00, 1, 2'b11, 0, 0, 1);
    step("R11 buffer blocked", 0, 1, 8'h00, 0, 0, 0, 0, 1);
    step("R5 write clears setup", 1, 0, 8'hFF, 0, 0, 0, 0, 1);
    step("R10 hold beats write", 1, 0, 8'h00, 0, 0, 0, 1, 1);
    step("R9 SIE wins over write", 1, 0, 8'h0F, 1, 2'b01, 0, 0, 0);
    step("R9 lock after conflict", 1, 0, 8'h0C, 0, 0, 0, 0, 0);
    step("R2 no-token code", 0, 1, 8'h00, 1, 2'b00, 0, 0, 0);
    step("R8 read during update keeps lock", 1, 0, 8'h09, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      step("R4/R6/R7 random", ($urandom % 3) == 0, ($urandom % 4) == 0, 8'($urandom),
           ($urandom % 5) == 0, 2'($urandom), ($urandom % 2) == 0,
           ($urandom % 8) == 0, ($urandom % 2) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule